// File: doc/BRIEF.md
# Serial-Addressed Dual-Port GPIO Expander

This block is a serial peripheral that adds two 8-bit bidirectional I/O ports to a host. The host addresses it over a four-wire serial link (select, clock, data in, data out). Each access is framed by the active-low select and carries three bytes. The first is an opcode holding a fixed device code, the three strap bits of this instance and a read flag. The second names a register. The third carries the write data, or is a filler byte during which the block returns the named register.

Per port the block holds a direction register, a pull-up enable register and an output latch, and it samples the port pins every clock. A direction bit of 0 turns the pin into an output that drives its latch bit. A pull-up bit requests a weak pull-up from the pad. Serial inputs are sampled on the rising serial clock and the reply changes after falling edges (clock idles low, most significant bit first). Serial inputs are taken to be synchronous to `clk` and several `clk` periods wide per serial half-period.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset both direction registers read 0xFF (all output enables low), latches and pull-up registers read 0x00, and the serial output is not driven.
- R2: An opcode of binary 0100 in bits 7:4, the strap value in bits 3:1 and 0 in bit 0, followed by a register address and a data byte, writes the data byte into that register on the rising clock edge that completes the third byte. Register state changes only on such an edge while the select is low.
- R3: Direction registers sit at 0x00 (port A) and 0x01 (port B). Each output enable bit is the inverse of its direction bit.
- R4: Pull-up registers sit at 0x0C (port A) and 0x0D (port B), and each drives its port's pull-up enable outputs bit for bit.
- R5: Output latches sit at 0x14 (port A) and 0x15 (port B), and each drives its port's output value bus.
- R6: An opcode with bit 0 set makes the block drive the serial output during the third byte with the addressed register, MSB first. The MSB is valid before the first rising edge of that byte, and each later bit appears after a falling edge.
- R7: Addresses 0x12 (port A) and 0x13 (port B) read the sampled pin levels. Writes to them change nothing.
- R8: An opcode whose device code or strap bits do not match causes no register write, and the serial output stays undriven for the whole frame.
- R9: Raising the select before the third byte completes abandons the frame with no write, and a high select never has the serial output driven.
- R10: Reads of any address outside the eight listed ones return 0x00, and writes to them have no effect.
- R11: Clock edges after the third byte of a frame are ignored until the select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_addr | input | 3 | Strap bits compared with opcode bits 3:1 |
| spi_csn | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pa_pull | output | 8 | Port A pull-up enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pb_pull | output | 8 | Port B pull-up enables |

## Verification
Every cycle, the assertions check these things: the reset values of the port controls, that port controls move only one cycle after a rising serial clock seen with select low, that the reply bit holds steady while the serial clock stays high, and that the reply is enabled only after a cycle of select low. Whether the right register was written, whether a mismatched or truncated frame was really dropped, and what bits a read returns show only in the bench scenarios. There a behavioural register model predicts every port output and the reply enable on every clock, and it predicts each read reply bit by bit.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int GPX_BYTE_W = 8;
    localparam int GPX_PORTS  = 2;
    localparam int GPX_CNT_W  = $clog2(GPX_BYTE_W);

    // register kind = address bits 7:1, port = address bit 0
    localparam logic [GPX_BYTE_W-2:0] GPX_K_DIR = 7'h00;
    localparam logic [GPX_BYTE_W-2:0] GPX_K_PU  = 7'h06;
    localparam logic [GPX_BYTE_W-2:0] GPX_K_PIN = 7'h09;
    localparam logic [GPX_BYTE_W-2:0] GPX_K_LAT = 7'h0A;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DONE = 2'd3
    } gpx_phase_e;

    typedef struct packed {
        logic                  sck;
        gpx_phase_e            phase;
        logic [GPX_CNT_W-1:0]  bitcnt;
        logic [GPX_BYTE_W-1:0] sh;
        logic [GPX_BYTE_W-1:0] addr;
        logic [GPX_BYTE_W-1:0] tx;
        logic                  sel;
        logic                  rd;
    } gpx_link_t;

    typedef struct packed {
        logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] dir;
        logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] pu;
        logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] lat;
        logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] pin;
    } gpx_regs_t;

endpackage

// File: rtl/gpx_spi_link.sv
module gpx_spi_link
    import gpx_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            hw_addr,
    input  logic                  spi_csn,
    input  logic                  spi_sck,
    input  logic                  spi_mosi,
    input  logic [GPX_BYTE_W-1:0] rd_data,
    output logic [GPX_BYTE_W-1:0] rd_addr,
    output logic                  wr_en,
    output logic [GPX_BYTE_W-1:0] wr_addr,
    output logic [GPX_BYTE_W-1:0] wr_data,
    output logic                  spi_miso,
    output logic                  spi_miso_oe
);

    localparam logic [GPX_CNT_W-1:0] LAST_BIT = GPX_CNT_W'(GPX_BYTE_W - 1);

    gpx_link_t q, d;
    logic [GPX_BYTE_W-1:0] byte_in;
    logic rise, fall;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        byte_in = {q.sh[GPX_BYTE_W-2:0], spi_mosi};
        rd_addr = byte_in;
        wr_addr = q.addr;
        wr_data = byte_in;
        rise    = spi_sck & ~q.sck;
        fall    = ~spi_sck & q.sck;
        d.sck   = spi_sck;

        if (spi_csn) begin
            d.phase  = PH_OPC;
            d.bitcnt = '0;
            d.sel    = 1'b0;
            d.rd     = 1'b0;
        end else if (rise && q.phase != PH_DONE) begin
            d.sh     = byte_in;
            d.bitcnt = q.bitcnt + 1'b1;
            if (q.bitcnt == LAST_BIT) begin
                unique case (q.phase)
                    PH_OPC: begin
                        d.sel   = (byte_in[7:4] == DEV_CODE) && (byte_in[3:1] == hw_addr);
                        d.rd    = byte_in[0];
                        d.phase = PH_ADDR;
                    end
                    PH_ADDR: begin
                        d.addr  = byte_in;
                        d.tx    = rd_data;
                        d.phase = PH_DATA;
                    end
                    PH_DATA: begin
                        wr_en   = q.sel & ~q.rd;
                        d.phase = PH_DONE;
                    end
                    default: d.phase = PH_DONE;
                endcase
            end
        end else if (fall && q.phase == PH_DATA && q.bitcnt != '0) begin
            d.tx = {q.tx[GPX_BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck: 1'b0, phase: PH_OPC, bitcnt: '0, sh: '0,
                   addr: '0, tx: '0, sel: 1'b0, rd: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign spi_miso    = q.tx[GPX_BYTE_W-1];
    assign spi_miso_oe = ~spi_csn & (q.phase == PH_DATA) & q.sel & q.rd;

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter logic [GPX_BYTE_W-1:0] DIR_RST = 8'hFF,
    parameter logic [GPX_BYTE_W-1:0] LAT_RST = 8'h00,
    parameter logic [GPX_BYTE_W-1:0] PU_RST  = 8'h00
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [GPX_BYTE_W-1:0]                wr_addr,
    input  logic [GPX_BYTE_W-1:0]                wr_data,
    input  logic [GPX_BYTE_W-1:0]                rd_addr,
    output logic [GPX_BYTE_W-1:0]                rd_data,
    input  logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] port_in,
    output logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] port_out,
    output logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] port_oe,
    output logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] port_pull
);

    gpx_regs_t q, d;
    logic wsel, rsel;

    always_comb begin
        d    = q;
        wsel = wr_addr[0];
        rsel = rd_addr[0];
        d.pin = port_in;
        if (wr_en) begin
            unique case (wr_addr[GPX_BYTE_W-1:1])
                GPX_K_DIR: d.dir[wsel] = wr_data;
                GPX_K_PU:  d.pu[wsel]  = wr_data;
                GPX_K_LAT: d.lat[wsel] = wr_data;
                default:   ;
            endcase
        end
        unique case (rd_addr[GPX_BYTE_W-1:1])
            GPX_K_DIR: rd_data = q.dir[rsel];
            GPX_K_PU:  rd_data = q.pu[rsel];
            GPX_K_PIN: rd_data = q.pin[rsel];
            GPX_K_LAT: rd_data = q.lat[rsel];
            default:   rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dir <= {GPX_PORTS{DIR_RST}};
            q.pu  <= {GPX_PORTS{PU_RST}};
            q.lat <= {GPX_PORTS{LAT_RST}};
            q.pin <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar p = 0; p < GPX_PORTS; p++) begin : g_port
        assign port_oe[p]   = ~q.dir[p];
        assign port_out[p]  = q.lat[p];
        assign port_pull[p] = q.pu[p];
    end

endmodule

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander
    import gpx_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b0100,
    parameter logic [7:0] DIR_RST  = 8'hFF,
    parameter logic [7:0] LAT_RST  = 8'h00,
    parameter logic [7:0] PU_RST   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hw_addr,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    output logic [7:0] pa_pull,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    output logic [7:0] pb_pull
);

    logic                                 wr_en;
    logic [GPX_BYTE_W-1:0]                wr_addr, wr_data, rd_addr, rd_data;
    logic [GPX_PORTS-1:0][GPX_BYTE_W-1:0] port_in, port_out, port_oe, port_pull;

    gpx_spi_link #(.DEV_CODE(DEV_CODE)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_addr     (hw_addr),
        .spi_csn     (spi_csn),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    gpx_regfile #(
        .DIR_RST (DIR_RST),
        .LAT_RST (LAT_RST),
        .PU_RST  (PU_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .port_in   (port_in),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .port_pull (port_pull)
    );

    assign port_in = {pb_in, pa_in};
    assign pa_out  = port_out[0];
    assign pb_out  = port_out[1];
    assign pa_oe   = port_oe[0];
    assign pb_oe   = port_oe[1];
    assign pa_pull = port_pull[0];
    assign pb_pull = port_pull[1];

endmodule

// File: rtl/spi_gpio_expander_chk.sv
module spi_gpio_expander_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_csn,
    input logic       spi_sck,
    input logic       spi_miso,
    input logic       spi_miso_oe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pa_pull,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pb_pull
);

    logic [47:0] ctl;
    assign ctl = {pa_out, pa_oe, pa_pull, pb_out, pb_oe, pb_pull};

    // R1: first cycle out of reset shows the reset register values
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pa_out == 8'h00 &&
                          pb_out == 8'h00 && pa_pull == 8'h00 && pb_pull == 8'h00 &&
                          !spi_miso_oe));

    // R2: port controls move only after a rising serial clock seen with select low
    a_r2_update_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl) |-> ($past(spi_sck) && !$past(spi_sck, 2) && !$past(spi_csn)));

    // R6: reply bit holds while the serial clock stays high
    a_r6_miso_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && spi_sck && $past(spi_sck)) |-> $stable(spi_miso));

    // R9: reply is enabled only after a cycle with select low
    a_r9_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !$past(spi_csn));

endmodule

bind spi_gpio_expander spi_gpio_expander_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_sck     (spi_sck),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .pa_out      (pa_out),
    .pa_oe       (pa_oe),
    .pa_pull     (pa_pull),
    .pb_out      (pb_out),
    .pb_oe       (pb_oe),
    .pb_pull     (pb_pull)
);

// File: tb/spi_gpio_expander_bench.sv
module spi_gpio_expander_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hw_addr = 3'b101;
    logic       spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pa_pull, pb_out, pb_oe, pb_pull;

    int  vecs = 0;
    int  errs = 0;
    bit  done = 0;
    bit  live = 0;

    // behavioural model
    logic [7:0] mreg [0:255];
    logic       exp_oe = 1'b0;

    always #2 clk = ~clk;

    spi_gpio_expander u_spi_gpio_expander (
        .clk(clk), .rst_n(rst_n), .hw_addr(hw_addr),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_pull(pa_pull),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_pull(pb_pull)
    );

    function automatic bit is_rw(input logic [7:0] a);
        return a inside {8'h00, 8'h01, 8'h0C, 8'h0D, 8'h14, 8'h15};
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] a);
        if (a == 8'h12) return pa_in;
        if (a == 8'h13) return pb_in;
        if (is_rw(a))   return mreg[a];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock against the model
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R3 output enables",   {pb_oe, pa_oe},   {~mreg[8'h01], ~mreg[8'h00]});
            chk("R5 output values",    {pb_out, pa_out}, {mreg[8'h15], mreg[8'h14]});
            chk("R4 pull-up enables",  {pb_pull, pa_pull}, {mreg[8'h0D], mreg[8'h0C]});
            chk("R8/R9 reply enable",  32'(spi_miso_oe), 32'(exp_oe));
        end
    end

    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input int nbits, output logic [7:0] got);
        logic [31:0] fr;
        logic        sel, rd;
        fr  = {b0, b1, b2, 8'hFF};
        sel = (b0[7:4] == 4'h4) && (b0[3:1] == hw_addr);
        rd  = b0[0];
        got = 8'h00;
        @(negedge clk); #1 spi_csn = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = fr[31-i];
            repeat (3) @(negedge clk);
            #1;
            if (i >= 16 && i < 24) got[23-i] = spi_miso;
            spi_sck = 1'b1;
            @(posedge clk); #1;
            if (i == 15 && sel && rd) exp_oe = 1'b1;
            if (i == 23) begin
                exp_oe = 1'b0;
                if (sel && !rd && is_rw(b1)) mreg[b1] = b2;
            end
            repeat (3) @(negedge clk);
            #1 spi_sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        #1 spi_csn = 1'b1;
        @(posedge clk); #1 exp_oe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        logic [7:0] dummy;
        xfer({4'h4, hw_addr, 1'b0}, a, v, 24, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [7:0] got;
        logic [7:0] exp;
        exp = mread(a);
        xfer({4'h4, hw_addr, 1'b1}, a, 8'h00, 24, got);
        chk(tag, 32'(got), 32'(exp));
    endtask

    task automatic finish_run;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] g;
        for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
        mreg[8'h00] = 8'hFF;
        mreg[8'h01] = 8'hFF;

        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enables after reset", {pa_oe, pb_oe}, 16'h0000);
        chk("R1 values after reset", {pa_out, pb_out, pa_pull, pb_pull}, 32'h0);
        chk("R1 reply undriven", 32'(spi_miso_oe), 32'h0);
        live = 1;

        // R2 R3 R5: port A direction and latch
        wr(8'h00, 8'h0F);
        wr(8'h14, 8'hA5);
        chk("R3 port A enables", 32'(pa_oe), 32'hF0);
        chk("R5 port A values", 32'(pa_out), 32'hA5);
        // port B and pull-ups (R4)
        wr(8'h01, 8'h00);
        wr(8'h15, 8'h3C);
        wr(8'h0D, 8'hFF);
        wr(8'h0C, 8'h81);
        chk("R4 port B pulls", 32'(pb_pull), 32'hFF);
        chk("R2 port B enables", 32'(pb_oe), 32'hFF);

        // R6 readback of every writable register
        rd_chk("R6 read dir A", 8'h00);
        rd_chk("R6 read dir B", 8'h01);
        rd_chk("R6 read pull A", 8'h0C);
        rd_chk("R6 read pull B", 8'h0D);
        rd_chk("R6 read latch A", 8'h14);
        rd_chk("R6 read latch B", 8'h15);

        // R7 pins
        pa_in = 8'h5A; pb_in = 8'hC3;
        repeat (3) @(negedge clk);
        rd_chk("R7 pins A", 8'h12);
        rd_chk("R7 pins B", 8'h13);
        wr(8'h13, 8'h00);
        wr(8'h12, 8'hFF);
        rd_chk("R7 latch B after pin write", 8'h15);
        pb_in = 8'h96;
        repeat (3) @(negedge clk);
        rd_chk("R7 pins B changed", 8'h13);

        // R8 mismatched strap and device code
        xfer(8'h40, 8'h14, 8'hFF, 24, g);
        xfer(8'h8A, 8'h14, 8'h11, 24, g);
        chk("R8 latch A untouched", 32'(pa_out), 32'hA5);
        xfer(8'h41, 8'h14, 8'h00, 24, g);
        xfer({4'h4, 3'b100, 1'b1}, 8'h15, 8'h00, 24, g);

        // R9 aborted frames
        xfer({4'h4, hw_addr, 1'b0}, 8'h14, 8'h00, 20, g);
        chk("R9 aborted write", 32'(pa_out), 32'hA5);
        xfer({4'h4, hw_addr, 1'b1}, 8'h15, 8'h00, 18, g);
        xfer({4'h4, hw_addr, 1'b0}, 8'h15, 8'h00, 12, g);
        rd_chk("R9 latch B intact", 8'h15);

        // R10 unmapped addresses
        wr(8'h07, 8'hEE);
        rd_chk("R10 unmapped 0x07", 8'h07);
        rd_chk("R10 unmapped 0x1F", 8'h1F);
        rd_chk("R10 unmapped 0x16", 8'h16);

        // R11 extra clocks after the third byte
        xfer({4'h4, hw_addr, 1'b0}, 8'h14, 8'h66, 32, g);
        chk("R11 latch A after long frame", 32'(pa_out), 32'h66);
        xfer({4'h4, hw_addr, 1'b1}, 8'h14, 8'h00, 32, g);
        chk("R11 long read", 32'(g), 32'h66);

        // R2 R6 sweep of patterns
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 8'h37 + 8'h1B);
            wr(8'h14 + 8'(k % 2), v);
            wr(8'h0C + 8'(k % 2), ~v);
            wr(8'h00 + 8'(k % 2), {v[3:0], v[7:4]});
            rd_chk("R6 sweep latch", 8'h14 + 8'(k % 2));
            rd_chk("R6 sweep dir", 8'h00 + 8'(k % 2));
        end

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule